// File: doc/BRIEF.md
# Snoopy Coherence Line State Controller

This block keeps the coherence state of a single cache line and decides what must happen for each event that reaches the line. There are three event kinds. A request from the local processor may cause a bus transaction. A bus response that completes one of this cache's own transactions installs a new state. A transaction snooped from another agent may make this cache give up the line, supply its data, or signal that it also holds a copy. The line state register is updated on the clock edge that follows a legal event. The bus command, the data-supply strobe, the shared-line strobe and the illegal flag are combinational, so they are valid in the same cycle as the event.

One transition table covers four protocol variants: MSI, MESI, MOSI and MOESI. The variant is chosen by a static parameter and reduces to two options: whether an Owned state exists and whether an Exclusive state exists. A second static parameter chooses between two ways of gaining write permission on a line that is already valid: an upgrade transaction, or a full read-exclusive. The Owned variants cannot work without upgrades, because a read-exclusive would overwrite the dirty data they still hold. That combination is rejected when the design is elaborated. Tag lookup, data storage, miss tracking and bus arbitration belong to other blocks.

Top module: `coh_line_ctrl`

## Requirements
- R1: The state is three bits {valid, writable, dirty}: Invalid 000, Shared 100, Exclusive 110, Owned 101, Modified 111. Reset gives Invalid. state_o takes the value of next_state_o on the clock edge that follows each event, and only states that exist in the chosen variant are ever held.
- R2: A local request on an Invalid line changes nothing in the state. A read (cmd 0) or a software or hardware prefetch (cmd 2, 3) issues a bus read (bus_cmd 0). A write (cmd 1) issues a read-exclusive (bus_cmd 4), since writes always allocate.
- R3: A local write to a Shared line, or to an Owned line in the variants that have Owned, issues an upgrade (bus_cmd 5) when upgrades are enabled and a read-exclusive (bus_cmd 4) when they are not.
- R4: On an Invalid line, a read-exclusive response (cmd 4) installs Modified. A read response (cmd 0) installs Exclusive in the variants that have Exclusive when shared_i is low. It installs Shared when shared_i is high, and always in the variants without Exclusive.
- R5: On a Shared or Owned line, the response that completes a write installs Modified. That response is the upgrade response (cmd 5) with upgrades enabled and the read-exclusive response (cmd 4) without them.
- R6: A snooped invalidate (cmd 6) or write-invalidate (cmd 7) sends every state to Invalid and supplies no data.
- R7: An Invalid line ignores a snooped read (cmd 0) and a snooped read-exclusive (cmd 4). It also ignores a snooped upgrade (cmd 5) when upgrades are enabled. No strobe fires and the state stays Invalid.
- R8: A Shared line goes to Invalid on a snooped read-exclusive, and on a snooped upgrade when upgrades are enabled. On a snooped read it stays Shared and pulses shared_o only in the variants that have Exclusive.
- R9: A Modified line pulses supply_o on a snooped read-exclusive and goes to Invalid. It also pulses supply_o on a snooped read and then goes to Owned where that state exists, or to Shared otherwise.
- R10: An Exclusive line pulses shared_o on a snooped read and moves to Shared. It goes to Invalid on a snooped read-exclusive.
- R11: An Owned line pulses supply_o on a snooped read and stays Owned. It pulses supply_o on a snooped read-exclusive and goes to Invalid. It goes to Invalid without supplying on a snooped upgrade.
- R12: Any other combination of state, event kind and command raises illegal_o. In that case bus_req_o, supply_o and shared_o stay low and the state is held. Event kind 0 is idle: it is legal and does nothing.
- R13: bus_req_o, bus_cmd_o, supply_o, shared_o, illegal_o and next_state_o depend only on the current inputs and state. They are valid in the same cycle as the event, and supply_o and shared_o never fire together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_kind_i | input | 2 | Event kind: 0 idle, 1 local request, 2 bus response, 3 snoop |
| cmd_i | input | 3 | Command: 0 read, 1 write, 2 sw prefetch, 3 hw prefetch, 4 read-exclusive, 5 upgrade, 6 invalidate, 7 write-invalidate |
| shared_i | input | 1 | Shared line sampled with a read response |
| state_o | output | 3 | Current line state {valid, writable, dirty} |
| next_state_o | output | 3 | State to be installed on the coming edge |
| bus_req_o | output | 1 | A bus transaction must be issued |
| bus_cmd_o | output | 3 | Bus command to issue, zero when bus_req_o is low |
| supply_o | output | 1 | This cache supplies the line's data for the snoop |
| shared_o | output | 1 | This cache drives the shared line for the snoop |
| illegal_o | output | 1 | The event is not a legal transition for the current state |

## Verification
The bench drives each event just after a falling edge. A quarter period later, before the next rising edge, it compares the command, the strobes, the illegal flag and the proposed next state, because all of these are due in the same cycle as the event. The registered state is due one rising edge after the event, so the bench reads it at the following falling edge. It brings each instance to a starting state through a short legal sequence of responses and snoops. It confirms that state, tries every event kind, command and shared_i value on it, and then returns the line to Invalid with a snooped invalidate. This sweep runs over every variant and upgrade setting that may be built.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        V_MSI   = 2'd0,
        V_MESI  = 2'd1,
        V_MOSI  = 2'd2,
        V_MOESI = 2'd3
    } variant_e;

    localparam int KIND_W = 2;
    localparam int CMD_W  = 3;
    localparam int ST_W   = 3;

    localparam logic [KIND_W-1:0] EV_IDLE  = 2'd0;
    localparam logic [KIND_W-1:0] EV_LOCAL = 2'd1;
    localparam logic [KIND_W-1:0] EV_RESP  = 2'd2;
    localparam logic [KIND_W-1:0] EV_SNOOP = 2'd3;

    localparam logic [CMD_W-1:0] CMD_READ    = 3'd0;
    localparam logic [CMD_W-1:0] CMD_WRITE   = 3'd1;
    localparam logic [CMD_W-1:0] CMD_PF_SW   = 3'd2;
    localparam logic [CMD_W-1:0] CMD_PF_HW   = 3'd3;
    localparam logic [CMD_W-1:0] CMD_READX   = 3'd4;
    localparam logic [CMD_W-1:0] CMD_UPGRADE = 3'd5;
    localparam logic [CMD_W-1:0] CMD_INVAL   = 3'd6;
    localparam logic [CMD_W-1:0] CMD_WRINV   = 3'd7;

    typedef struct packed {
        logic valid;
        logic writable;
        logic dirty;
    } line_st_t;

    localparam line_st_t ST_I = 3'b000;
    localparam line_st_t ST_S = 3'b100;
    localparam line_st_t ST_E = 3'b110;
    localparam line_st_t ST_O = 3'b101;
    localparam line_st_t ST_M = 3'b111;

    typedef struct packed {
        logic             legal;
        line_st_t         nxt;
        logic             bus_req;
        logic [CMD_W-1:0] bus_cmd;
        logic             supply;
        logic             shared;
    } verdict_t;

    function automatic bit variant_has_owned(variant_e v);
        return (v == V_MOSI) || (v == V_MOESI);
    endfunction

    function automatic bit variant_has_excl(variant_e v);
        return (v == V_MESI) || (v == V_MOESI);
    endfunction

endpackage

// File: rtl/coh_local_dec.sv
module coh_local_dec
    import coh_pkg::*;
#(
    parameter bit HAS_OWNED   = 1'b0,
    parameter bit USE_UPGRADE = 1'b1
) (
    input  line_st_t         cur_i,
    input  logic [CMD_W-1:0] cmd_i,
    output verdict_t         verdict_o
);

    localparam logic [CMD_W-1:0] GAIN_CMD = USE_UPGRADE ? CMD_UPGRADE : CMD_READX;

    logic owned_ok;
    assign owned_ok = HAS_OWNED && (cur_i == ST_O);

    always_comb begin
        verdict_o     = '0;
        verdict_o.nxt = cur_i;
        if (cur_i == ST_I) begin
            case (cmd_i)
                CMD_READ, CMD_PF_SW, CMD_PF_HW: begin
                    verdict_o.legal   = 1'b1;
                    verdict_o.bus_req = 1'b1;
                    verdict_o.bus_cmd = CMD_READ;
                end
                CMD_WRITE: begin
                    verdict_o.legal   = 1'b1;
                    verdict_o.bus_req = 1'b1;
                    verdict_o.bus_cmd = CMD_READX;
                end
                default: verdict_o.legal = 1'b0;
            endcase
        end else if ((cmd_i == CMD_WRITE) && ((cur_i == ST_S) || owned_ok)) begin
            verdict_o.legal   = 1'b1;
            verdict_o.bus_req = 1'b1;
            verdict_o.bus_cmd = GAIN_CMD;
        end
    end

endmodule

// File: rtl/coh_resp_dec.sv
module coh_resp_dec
    import coh_pkg::*;
#(
    parameter bit HAS_OWNED   = 1'b0,
    parameter bit HAS_EXCL    = 1'b0,
    parameter bit USE_UPGRADE = 1'b1
) (
    input  line_st_t         cur_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             shared_i,
    output verdict_t         verdict_o
);

    localparam logic [CMD_W-1:0] GAIN_RESP = USE_UPGRADE ? CMD_UPGRADE : CMD_READX;

    logic holds_copy;
    assign holds_copy = (cur_i == ST_S) || (HAS_OWNED && (cur_i == ST_O));

    always_comb begin
        verdict_o     = '0;
        verdict_o.nxt = cur_i;
        if (cur_i == ST_I) begin
            if (cmd_i == CMD_READX) begin
                verdict_o.legal = 1'b1;
                verdict_o.nxt   = ST_M;
            end else if (cmd_i == CMD_READ) begin
                verdict_o.legal = 1'b1;
                verdict_o.nxt   = (HAS_EXCL && !shared_i) ? ST_E : ST_S;
            end
        end else if (holds_copy && (cmd_i == GAIN_RESP)) begin
            verdict_o.legal = 1'b1;
            verdict_o.nxt   = ST_M;
        end
    end

endmodule

// File: rtl/coh_snoop_dec.sv
module coh_snoop_dec
    import coh_pkg::*;
#(
    parameter bit HAS_OWNED   = 1'b0,
    parameter bit HAS_EXCL    = 1'b0,
    parameter bit USE_UPGRADE = 1'b1
) (
    input  line_st_t         cur_i,
    input  logic [CMD_W-1:0] cmd_i,
    output verdict_t         verdict_o
);

    always_comb begin
        verdict_o     = '0;
        verdict_o.nxt = cur_i;
        if ((cmd_i == CMD_INVAL) || (cmd_i == CMD_WRINV)) begin
            verdict_o.legal = 1'b1;
            verdict_o.nxt   = ST_I;
        end else begin
            case (cur_i)
                ST_I: begin
                    verdict_o.legal = (cmd_i == CMD_READ) || (cmd_i == CMD_READX) ||
                                      (USE_UPGRADE && (cmd_i == CMD_UPGRADE));
                end
                ST_S: begin
                    if (cmd_i == CMD_READ) begin
                        verdict_o.legal  = 1'b1;
                        verdict_o.shared = HAS_EXCL;
                    end else if ((cmd_i == CMD_READX) ||
                                 (USE_UPGRADE && (cmd_i == CMD_UPGRADE))) begin
                        verdict_o.legal = 1'b1;
                        verdict_o.nxt   = ST_I;
                    end
                end
                ST_E: begin
                    if (HAS_EXCL && (cmd_i == CMD_READ)) begin
                        verdict_o.legal  = 1'b1;
                        verdict_o.shared = 1'b1;
                        verdict_o.nxt    = ST_S;
                    end else if (HAS_EXCL && (cmd_i == CMD_READX)) begin
                        verdict_o.legal = 1'b1;
                        verdict_o.nxt   = ST_I;
                    end
                end
                ST_M: begin
                    if (cmd_i == CMD_READ) begin
                        verdict_o.legal  = 1'b1;
                        verdict_o.supply = 1'b1;
                        verdict_o.nxt    = HAS_OWNED ? ST_O : ST_S;
                    end else if (cmd_i == CMD_READX) begin
                        verdict_o.legal  = 1'b1;
                        verdict_o.supply = 1'b1;
                        verdict_o.nxt    = ST_I;
                    end
                end
                ST_O: begin
                    if (HAS_OWNED && (cmd_i == CMD_READ)) begin
                        verdict_o.legal  = 1'b1;
                        verdict_o.supply = 1'b1;
                    end else if (HAS_OWNED && (cmd_i == CMD_READX)) begin
                        verdict_o.legal  = 1'b1;
                        verdict_o.supply = 1'b1;
                        verdict_o.nxt    = ST_I;
                    end else if (HAS_OWNED && (cmd_i == CMD_UPGRADE)) begin
                        verdict_o.legal = 1'b1;
                        verdict_o.nxt   = ST_I;
                    end
                end
                default: verdict_o.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter variant_e VARIANT     = V_MOESI,
    parameter bit       USE_UPGRADE = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [KIND_W-1:0] ev_kind_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              shared_i,
    output logic [ST_W-1:0]   state_o,
    output logic [ST_W-1:0]   next_state_o,
    output logic              bus_req_o,
    output logic [CMD_W-1:0]  bus_cmd_o,
    output logic              supply_o,
    output logic              shared_o,
    output logic              illegal_o
);

    localparam bit HAS_OWNED = variant_has_owned(VARIANT);
    localparam bit HAS_EXCL  = variant_has_excl(VARIANT);

    generate
        if (HAS_OWNED && !USE_UPGRADE) begin : g_bad_cfg
            $error("coh_line_ctrl: an Owned-state variant needs upgrade transactions");
        end
    endgenerate

    typedef struct packed {
        line_st_t         line;
        logic             bus_req;
        logic [CMD_W-1:0] bus_cmd;
        logic             supply;
        logic             shared;
        logic             illegal;
    } ctl_t;

    line_st_t state_q;
    ctl_t     ctl_d;
    line_st_t state_d;
    verdict_t v_local;
    verdict_t v_resp;
    verdict_t v_snoop;

    coh_local_dec #(
        .HAS_OWNED   (HAS_OWNED),
        .USE_UPGRADE (USE_UPGRADE)
    ) u_local (
        .cur_i     (state_q),
        .cmd_i     (cmd_i),
        .verdict_o (v_local)
    );

    coh_resp_dec #(
        .HAS_OWNED   (HAS_OWNED),
        .HAS_EXCL    (HAS_EXCL),
        .USE_UPGRADE (USE_UPGRADE)
    ) u_resp (
        .cur_i     (state_q),
        .cmd_i     (cmd_i),
        .shared_i  (shared_i),
        .verdict_o (v_resp)
    );

    coh_snoop_dec #(
        .HAS_OWNED   (HAS_OWNED),
        .HAS_EXCL    (HAS_EXCL),
        .USE_UPGRADE (USE_UPGRADE)
    ) u_snoop (
        .cur_i     (state_q),
        .cmd_i     (cmd_i),
        .verdict_o (v_snoop)
    );

    always_comb begin
        verdict_t pick;
        pick       = '0;
        pick.legal = 1'b1;
        pick.nxt   = state_q;
        case (ev_kind_i)
            EV_LOCAL: pick = v_local;
            EV_RESP:  pick = v_resp;
            EV_SNOOP: pick = v_snoop;
            default:  pick.legal = 1'b1;
        endcase

        ctl_d = '0;
        if (pick.legal) begin
            ctl_d.line    = pick.nxt;
            ctl_d.bus_req = pick.bus_req;
            ctl_d.bus_cmd = pick.bus_req ? pick.bus_cmd : '0;
            ctl_d.supply  = pick.supply;
            ctl_d.shared  = pick.shared;
        end else begin
            ctl_d.line    = state_q;
            ctl_d.illegal = 1'b1;
        end
        state_d = ctl_d.line;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_I;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o      = state_q;
    assign next_state_o = ctl_d.line;
    assign bus_req_o    = ctl_d.bus_req;
    assign bus_cmd_o    = ctl_d.bus_cmd;
    assign supply_o     = ctl_d.supply;
    assign shared_o     = ctl_d.shared;
    assign illegal_o    = ctl_d.illegal;

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
    import coh_pkg::*;
#(
    parameter variant_e VARIANT     = V_MOESI,
    parameter bit       USE_UPGRADE = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [KIND_W-1:0] ev_kind_i,
    input logic [CMD_W-1:0]  cmd_i,
    input logic [ST_W-1:0]   state_o,
    input logic [ST_W-1:0]   next_state_o,
    input logic              bus_req_o,
    input logic              supply_o,
    input logic              shared_o,
    input logic              illegal_o
);

    localparam bit HAS_OWNED = variant_has_owned(VARIANT);
    localparam bit HAS_EXCL  = variant_has_excl(VARIANT);

    // R1: the register follows the proposed next state
    p_follow_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (state_o == $past(next_state_o)));

    // R1: only states of the chosen variant are held
    p_state_exists_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'b000) || (state_o == 3'b100) || (state_o == 3'b111) ||
        (HAS_EXCL && (state_o == 3'b110)) || (HAS_OWNED && (state_o == 3'b101)));

    // R12: an illegal event leaves no trace
    p_illegal_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (!bus_req_o && !supply_o && !shared_o));

    p_illegal_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |=> $stable(state_o));

    // R6: invalidating snoops always empty the line
    p_inval_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ev_kind_i == EV_SNOOP) && ((cmd_i == CMD_INVAL) || (cmd_i == CMD_WRINV)))
        |=> (state_o == 3'b000));

    // R9: data is supplied only in answer to a snoop
    p_supply_on_snoop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        supply_o |-> (ev_kind_i == EV_SNOOP));

    // R2: bus transactions come only from local requests
    p_bus_from_local_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> (ev_kind_i == EV_LOCAL));

    // R13: the two snoop strobes never fire together
    p_one_strobe_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(supply_o && shared_o));

    // R4: a read-exclusive fill of an empty line lands in Modified
    p_readx_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ev_kind_i == EV_RESP) && (cmd_i == CMD_READX) && (state_o == 3'b000))
        |=> (state_o == 3'b111));

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(
    .VARIANT     (VARIANT),
    .USE_UPGRADE (USE_UPGRADE)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ev_kind_i    (ev_kind_i),
    .cmd_i        (cmd_i),
    .state_o      (state_o),
    .next_state_o (next_state_o),
    .bus_req_o    (bus_req_o),
    .supply_o     (supply_o),
    .shared_o     (shared_o),
    .illegal_o    (illegal_o)
);

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
    import coh_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 6;
    localparam int VAR_TAB [NCFG] = '{0, 0, 1, 1, 2, 3};
    localparam bit UPG_TAB [NCFG] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0] kind [NCFG];
    logic [2:0] cmd  [NCFG];
    logic       shr  [NCFG];
    logic [2:0] st_o [NCFG];
    logic [2:0] nx_o [NCFG];
    logic       br_o [NCFG];
    logic [2:0] bc_o [NCFG];
    logic       sp_o [NCFG];
    logic       sh_o [NCFG];
    logic       il_o [NCFG];

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        coh_line_ctrl #(
            .VARIANT     (variant_e'(VAR_TAB[g])),
            .USE_UPGRADE (UPG_TAB[g])
        ) uut (
            .clk_i        (clk),
            .rst_ni       (rst_n),
            .ev_kind_i    (kind[g]),
            .cmd_i        (cmd[g]),
            .shared_i     (shr[g]),
            .state_o      (st_o[g]),
            .next_state_o (nx_o[g]),
            .bus_req_o    (br_o[g]),
            .bus_cmd_o    (bc_o[g]),
            .supply_o     (sp_o[g]),
            .shared_o     (sh_o[g]),
            .illegal_o    (il_o[g])
        );
    end

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // expected {illegal, next[2:0], bus_req, bus_cmd[2:0], supply, shared}
    function automatic logic [9:0] model(int vid, bit upg, logic [1:0] k,
                                         logic [2:0] c, logic [2:0] s, logic sh);
        bit ho = (vid >= 2);
        bit he = (vid == 1) || (vid == 3);
        bit ok = 1'b0;
        logic [2:0] n  = s;
        logic       br = 1'b0;
        logic [2:0] bc = 3'd0;
        logic       sp = 1'b0;
        logic       sa = 1'b0;
        if (k == 2'd0) ok = 1'b1;
        if (k == 2'd1) begin
            if (s == 3'b000 && (c == 3'd0 || c == 3'd2 || c == 3'd3)) begin
                ok = 1'b1; br = 1'b1; bc = 3'd0;             // R2
            end
            if (s == 3'b000 && c == 3'd1) begin
                ok = 1'b1; br = 1'b1; bc = 3'd4;             // R2
            end
            if (c == 3'd1 && (s == 3'b100 || (ho && s == 3'b101))) begin
                ok = 1'b1; br = 1'b1; bc = upg ? 3'd5 : 3'd4; // R3
            end
        end
        if (k == 2'd2) begin
            if (s == 3'b000 && c == 3'd4) begin ok = 1'b1; n = 3'b111; end
            if (s == 3'b000 && c == 3'd0) begin
                ok = 1'b1; n = (he && !sh) ? 3'b110 : 3'b100;  // R4
            end
            if ((s == 3'b100 || (ho && s == 3'b101)) && c == (upg ? 3'd5 : 3'd4)) begin
                ok = 1'b1; n = 3'b111;                        // R5
            end
        end
        if (k == 2'd3) begin
            if (c == 3'd6 || c == 3'd7) begin ok = 1'b1; n = 3'b000; end // R6
            else if (s == 3'b000) ok = (c == 3'd0) || (c == 3'd4) || (upg && c == 3'd5);
            else if (s == 3'b100) begin
                if (c == 3'd0) begin ok = 1'b1; sa = he; end
                if (c == 3'd4 || (upg && c == 3'd5)) begin ok = 1'b1; n = 3'b000; end
            end else if (s == 3'b111) begin
                if (c == 3'd0) begin ok = 1'b1; sp = 1'b1; n = ho ? 3'b101 : 3'b100; end
                if (c == 3'd4) begin ok = 1'b1; sp = 1'b1; n = 3'b000; end
            end else if (s == 3'b110) begin
                if (c == 3'd0) begin ok = 1'b1; sa = 1'b1; n = 3'b100; end
                if (c == 3'd4) begin ok = 1'b1; n = 3'b000; end
            end else if (s == 3'b101) begin
                if (c == 3'd0) begin ok = 1'b1; sp = 1'b1; end
                if (c == 3'd4) begin ok = 1'b1; sp = 1'b1; n = 3'b000; end
                if (c == 3'd5) begin ok = 1'b1; n = 3'b000; end
            end
        end
        if (!ok) return {1'b1, s, 6'b0};
        return {1'b0, n, br, bc, sp, sa};
    endfunction

    function automatic string tag_of(logic [1:0] k, logic [2:0] c, logic [2:0] s, bit ill);
        if (ill || k == 2'd0) return "R12";
        if (k == 2'd1) return (s == 3'b000) ? "R2" : "R3";
        if (k == 2'd2) return (s == 3'b000) ? "R4" : "R5";
        if (c == 3'd6 || c == 3'd7) return "R6";
        case (s)
            3'b000:  return "R7";
            3'b100:  return "R8";
            3'b111:  return "R9";
            3'b110:  return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, int ci, logic [9:0] act, logic [9:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cfg%0d: actual %b expected %b", tag, ci, act, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic apply(int ci, logic [1:0] k, logic [2:0] c, logic sh);
        kind[ci] = k; cmd[ci] = c; shr[ci] = sh;
        @(negedge clk);
        kind[ci] = 2'd0; cmd[ci] = 3'd0; shr[ci] = 1'b0;
    endtask

    task automatic reach(int ci, logic [2:0] s);
        case (s)
            3'b100: apply(ci, 2'd2, 3'd0, 1'b1);
            3'b110: apply(ci, 2'd2, 3'd0, 1'b0);
            3'b111: apply(ci, 2'd2, 3'd4, 1'b0);
            3'b101: begin
                apply(ci, 2'd2, 3'd4, 1'b0);
                apply(ci, 2'd3, 3'd0, 1'b0);
            end
            default: ;
        endcase
    endtask

    initial begin
        logic [2:0] st_list [5] = '{3'b000, 3'b100, 3'b110, 3'b111, 3'b101};
        for (int i = 0; i < NCFG; i++) begin
            kind[i] = 2'd0; cmd[i] = 3'd0; shr[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state is Invalid and idle raises nothing
        for (int i = 0; i < NCFG; i++)
            check("R1", i, {il_o[i], st_o[i], 6'b0}, 10'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int ci = 0; ci < NCFG; ci++) begin
            bit ho = (VAR_TAB[ci] >= 2);
            bit he = (VAR_TAB[ci] == 1) || (VAR_TAB[ci] == 3);
            for (int si = 0; si < 5; si++) begin
                logic [2:0] s = st_list[si];
                if (s == 3'b110 && !he) continue;
                if (s == 3'b101 && !ho) continue;
                for (int k = 0; k < 4; k++) begin
                    for (int c = 0; c < 8; c++) begin
                        for (int sh = 0; sh < 2; sh++) begin
                            logic [9:0] exp;
                            logic [9:0] act;
                            reach(ci, s);
                            // R1: starting state reached through legal events
                            check("R1", ci, {7'b0, st_o[ci]}, {7'b0, s});
                            exp = model(VAR_TAB[ci], UPG_TAB[ci], k[1:0], c[2:0], s, sh[0]);
                            kind[ci] = k[1:0]; cmd[ci] = c[2:0]; shr[ci] = sh[0];
                            #(CLK_PERIOD/4);
                            // R13: strobes and next state due in the event cycle
                            act = {il_o[ci], nx_o[ci], br_o[ci], bc_o[ci], sp_o[ci], sh_o[ci]};
                            check({tag_of(k[1:0], c[2:0], s, exp[9]), "/R13"}, ci, act, exp);
                            @(negedge clk);
                            kind[ci] = 2'd0; cmd[ci] = 3'd0; shr[ci] = 1'b0;
                            // R1: registered state one edge after the event
                            check("R1", ci, {7'b0, st_o[ci]}, {7'b0, exp[8:6]});
                            apply(ci, 2'd3, 3'd6, 1'b0);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule